// File: doc/BRIEF.md
# Warp Issue Scheduler

This block sits in front of the fetch stage of a single SIMD pipeline. It interleaves instruction fetch from several warps. A warp is a group of threads that all run the same instruction on different data, so each warp needs only one shared program counter. In every cycle the scheduler picks one warp that is ready, if there is one, and presents that warp's ID and PC to fetch.

An issued warp stays unavailable until the pipeline reports its completion. The pipeline therefore never holds two instructions from the same warp and needs no dependence interlocks. Latency is hidden by rotating among the warps that are ready, never by stalling.

A completion can do one of three things:
- return the warp to ready with the next PC;
- park it until a memory wake-up arrives;
- retire it to idle.

Warps are started through a launch port, which supplies the start PC.

Top module: `warp_sched`

## Requirements
- R1: After reset all warps are idle, `done_o` is 1 and `issue_valid_o` is 0.
- R2: A launch naming an idle warp makes that warp ready with PC = `launch_pc_i`. A launch naming a warp that is not idle has no effect on its state or PC.
- R3: `issue_valid_o` is 1 exactly when at least one warp is ready. The issued warp goes in flight at the next edge and is not issued again until its completion.
- R4: When several warps are ready, the one issued is the first ready warp found scanning upward (modulo the warp count) from the ID after the most recently issued warp. After reset the most recent issue is taken to be the highest ID, so the scan starts at warp 0.
- R5: A completion (`cmpl_valid_i`) for an in-flight warp with both flags low returns it to ready with PC advanced by 4.
- R6: A completion with `cmpl_mem_i`=1 and `cmpl_exit_i`=0 advances the PC by 4 and parks the warp in memory wait. A parked warp is never issued.
- R7: A wake pulse (`wake_valid_i`) naming a parked warp makes it ready. A wake naming any other warp has no effect.
- R8: A completion with `cmpl_exit_i`=1 returns the warp to idle, whatever the value of `cmpl_mem_i`.
- R9: `done_o` is 1 exactly when every warp is idle. No issue occurs while `done_o` is 1.
- R10: A completion naming a warp that is not in flight has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| launch_valid_i | input | 1 | launch strobe |
| launch_id_i | input | 3 | warp to launch |
| launch_pc_i | input | 32 | start PC for the launched warp |
| cmpl_valid_i | input | 1 | completion strobe |
| cmpl_id_i | input | 3 | completing warp |
| cmpl_mem_i | input | 1 | completion was a long-latency memory access |
| cmpl_exit_i | input | 1 | completing warp has finished |
| wake_valid_i | input | 1 | memory-done strobe |
| wake_id_i | input | 3 | warp whose memory access finished |
| issue_valid_o | output | 1 | an issue is presented this cycle |
| issue_id_o | output | 3 | issued warp |
| issue_pc_o | output | 32 | PC of the issued warp |
| done_o | output | 1 | all warps idle |

## Verification
Launch, completion and wake strobes are registered at the next rising edge. The issue outputs decode from registered state, so a warp made ready at edge k is presented in the cycle after edge k. When several warps become ready at once, the issues follow one per cycle in round-robin order.

The driver drives strobes just after a falling edge and pushes the expected (ID, PC) for each issue when it applies the stimulus that causes it. The monitor samples the issue outputs at every falling edge and pops and compares one entry per observed issue, so an early, late, missing or unexpected issue shows up as a mismatch. Checks that nothing issues, and checks of `done_o`, are made two or more falling edges after the strobe that should have settled the state.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_READY = 2'd1,
    WS_BUSY  = 2'd2,
    WS_WAIT  = 2'd3
  } warp_st_e;
endpackage

// File: rtl/warp_slot.sv
module warp_slot
  import warp_sched_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            launch_i,
  input  logic [PC_W-1:0] launch_pc_i,
  input  logic            issue_i,
  input  logic            cmpl_i,
  input  logic            cmpl_mem_i,
  input  logic            cmpl_exit_i,
  input  logic            wake_i,
  output warp_st_e        state_o,
  output logic [PC_W-1:0] pc_o
);
  warp_st_e        st_q, st_d;
  logic [PC_W-1:0] pc_q, pc_d;

  always_comb begin
    st_d = st_q;
    pc_d = pc_q;
    unique case (st_q)
      WS_IDLE: if (launch_i) begin
        st_d = WS_READY;
        pc_d = launch_pc_i;
      end
      WS_READY: if (issue_i) st_d = WS_BUSY;
      WS_BUSY: if (cmpl_i) begin
        pc_d = pc_q + PC_W'(PC_STEP);
        if (cmpl_exit_i)     st_d = WS_IDLE;
        else if (cmpl_mem_i) st_d = WS_WAIT;
        else                 st_d = WS_READY;
      end
      WS_WAIT: if (wake_i) st_d = WS_READY;
      default: st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= WS_IDLE;
      pc_q <= '0;
    end else begin
      st_q <= st_d;
      pc_q <= pc_d;
    end
  end

  assign state_o = st_q;
  assign pc_o    = pc_q;
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N    = 8,
  parameter int ID_W = $clog2(N)
) (
  input  logic [N-1:0]    req_i,
  input  logic [ID_W-1:0] last_i,
  output logic            gnt_valid_o,
  output logic [ID_W-1:0] gnt_id_o
);
  // scan downward in distance so the closest requester after last_i wins
  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_id_o    = '0;
    for (int k = N; k >= 1; k--) begin
      int idx;
      idx = (int'(last_i) + k) % N;
      if (req_i[idx]) begin
        gnt_valid_o = 1'b1;
        gnt_id_o    = ID_W'(idx);
      end
    end
  end
endmodule

// File: rtl/warp_sched.sv
module warp_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int PC_W      = 32,
  parameter int PC_STEP   = 4,
  localparam int ID_W     = $clog2(NUM_WARPS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            launch_valid_i,
  input  logic [ID_W-1:0] launch_id_i,
  input  logic [PC_W-1:0] launch_pc_i,
  input  logic            cmpl_valid_i,
  input  logic [ID_W-1:0] cmpl_id_i,
  input  logic            cmpl_mem_i,
  input  logic            cmpl_exit_i,
  input  logic            wake_valid_i,
  input  logic [ID_W-1:0] wake_id_i,
  output logic            issue_valid_o,
  output logic [ID_W-1:0] issue_id_o,
  output logic [PC_W-1:0] issue_pc_o,
  output logic            done_o
);
  warp_st_e        st   [NUM_WARPS];
  logic [PC_W-1:0] pc   [NUM_WARPS];
  logic [NUM_WARPS-1:0] idle_vec, ready_vec, busy_vec, wait_vec;
  logic [ID_W-1:0] last_q;
  logic            gnt_valid;
  logic [ID_W-1:0] gnt_id;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    localparam logic [ID_W-1:0] WID = ID_W'(w);
    warp_slot #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .launch_i    (launch_valid_i && launch_id_i == WID),
      .launch_pc_i (launch_pc_i),
      .issue_i     (gnt_valid && gnt_id == WID),
      .cmpl_i      (cmpl_valid_i && cmpl_id_i == WID),
      .cmpl_mem_i  (cmpl_mem_i),
      .cmpl_exit_i (cmpl_exit_i),
      .wake_i      (wake_valid_i && wake_id_i == WID),
      .state_o     (st[w]),
      .pc_o        (pc[w])
    );
    assign idle_vec[w]  = st[w] == WS_IDLE;
    assign ready_vec[w] = st[w] == WS_READY;
    assign busy_vec[w]  = st[w] == WS_BUSY;
    assign wait_vec[w]  = st[w] == WS_WAIT;
  end

  rr_pick #(.N(NUM_WARPS), .ID_W(ID_W)) u_pick (
    .req_i       (ready_vec),
    .last_i      (last_q),
    .gnt_valid_o (gnt_valid),
    .gnt_id_o    (gnt_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        last_q <= ID_W'(NUM_WARPS - 1);
    else if (gnt_valid) last_q <= gnt_id;
  end

  assign issue_valid_o = gnt_valid;
  assign issue_id_o    = gnt_id;
  assign issue_pc_o    = pc[gnt_id];
  assign done_o        = &idle_vec;
endmodule

// File: rtl/warp_sched_chk.sv
module warp_sched_chk #(
  parameter int NUM_WARPS = 8,
  parameter int PC_W      = 32,
  parameter int ID_W      = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 launch_valid_i,
  input logic [ID_W-1:0]      launch_id_i,
  input logic                 cmpl_valid_i,
  input logic [ID_W-1:0]      cmpl_id_i,
  input logic                 cmpl_mem_i,
  input logic                 cmpl_exit_i,
  input logic                 wake_valid_i,
  input logic [ID_W-1:0]      wake_id_i,
  input logic                 issue_valid_o,
  input logic [ID_W-1:0]      issue_id_o,
  input logic                 done_o,
  input logic [NUM_WARPS-1:0] idle_vec,
  input logic [NUM_WARPS-1:0] ready_vec,
  input logic [NUM_WARPS-1:0] busy_vec,
  input logic [NUM_WARPS-1:0] wait_vec
);
  AST_ISSUE_FROM_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> ready_vec[issue_id_o]); // R3
  AST_NO_REISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |=> !(issue_valid_o && issue_id_o == $past(issue_id_o))); // R3
  AST_LAUNCH_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_valid_i && idle_vec[launch_id_i] |=> ready_vec[$past(launch_id_i)]); // R2
  AST_MEM_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_valid_i && busy_vec[cmpl_id_i] && cmpl_mem_i && !cmpl_exit_i
    |=> wait_vec[$past(cmpl_id_i)]); // R6
  AST_WAKE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_valid_i && wait_vec[wake_id_i] |=> ready_vec[$past(wake_id_i)]); // R7
  AST_EXIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_valid_i && busy_vec[cmpl_id_i] && cmpl_exit_i |=> idle_vec[$past(cmpl_id_i)]); // R8
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !issue_valid_o); // R9
endmodule

bind warp_sched warp_sched_chk #(.NUM_WARPS(NUM_WARPS), .PC_W(PC_W), .ID_W(ID_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .launch_valid_i (launch_valid_i),
  .launch_id_i    (launch_id_i),
  .cmpl_valid_i   (cmpl_valid_i),
  .cmpl_id_i      (cmpl_id_i),
  .cmpl_mem_i     (cmpl_mem_i),
  .cmpl_exit_i    (cmpl_exit_i),
  .wake_valid_i   (wake_valid_i),
  .wake_id_i      (wake_id_i),
  .issue_valid_o  (issue_valid_o),
  .issue_id_o     (issue_id_o),
  .done_o         (done_o),
  .idle_vec       (idle_vec),
  .ready_vec      (ready_vec),
  .busy_vec       (busy_vec),
  .wait_vec       (wait_vec)
);

// File: tb/tb_warp_sched.sv
`timescale 1ns/1ps
module tb_warp_sched;
  localparam int ID_W = 3;
  localparam int PC_W = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic launch_valid_i = 1'b0;
  logic [ID_W-1:0] launch_id_i = '0;
  logic [PC_W-1:0] launch_pc_i = '0;
  logic cmpl_valid_i = 1'b0;
  logic [ID_W-1:0] cmpl_id_i = '0;
  logic cmpl_mem_i = 1'b0;
  logic cmpl_exit_i = 1'b0;
  logic wake_valid_i = 1'b0;
  logic [ID_W-1:0] wake_id_i = '0;
  logic issue_valid_o;
  logic [ID_W-1:0] issue_id_o;
  logic [PC_W-1:0] issue_pc_o;
  logic done_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [ID_W+PC_W-1:0] exp_q[$];

  always #5 clk_i = ~clk_i;

  warp_sched dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input int id, input logic [PC_W-1:0] pc);
    exp_q.push_back({ID_W'(id), pc});
  endtask

  task automatic cycle();
    @(negedge clk_i);
    launch_valid_i = 1'b0;
    cmpl_valid_i   = 1'b0;
    cmpl_mem_i     = 1'b0;
    cmpl_exit_i    = 1'b0;
    wake_valid_i   = 1'b0;
  endtask

  task automatic launch(input int id, input logic [PC_W-1:0] pc);
    launch_valid_i = 1'b1;
    launch_id_i    = ID_W'(id);
    launch_pc_i    = pc;
  endtask

  task automatic cmpl(input int id, input bit mem, input bit ex);
    cmpl_valid_i = 1'b1;
    cmpl_id_i    = ID_W'(id);
    cmpl_mem_i   = mem;
    cmpl_exit_i  = ex;
  endtask

  task automatic wake(input int id);
    wake_valid_i = 1'b1;
    wake_id_i    = ID_W'(id);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: one scoreboard entry per observed issue (R3, R4, R5)
  always @(negedge clk_i) begin
    if (rst_ni && issue_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected issue", {29'd0, issue_id_o, issue_pc_o}, 64'd0);
      end else begin
        logic [ID_W+PC_W-1:0] e;
        e = exp_q.pop_front();
        chk({issue_id_o, issue_pc_o} == e, "R3/R4 issue id,pc",
            {29'd0, issue_id_o, issue_pc_o}, {29'd0, e});
      end
    end
  end

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(done_o == 1'b1, "R1 done after reset", done_o, 1);
    chk(issue_valid_o == 1'b0, "R1 no issue after reset", issue_valid_o, 0);
    rst_ni = 1'b1;
    cycle();

    // R2 launch, one warp ready at a time
    push(0, 32'h100); launch(0, 32'h100); cycle();
    push(1, 32'h200); launch(1, 32'h200); cycle();
    push(2, 32'h300); launch(2, 32'h300); cycle();
    cycle();

    // R6 memory completion parks warp 0
    cmpl(0, 1'b1, 1'b0); cycle();
    cycle(); cycle();
    chk(issue_valid_o == 1'b0, "R6 parked warp not issued", issue_valid_o, 0);
    chk(done_o == 1'b0, "R9 done low with live warps", done_o, 0);

    // R4/R5/R7: three warps ready at once, last issued = 2
    push(5, 32'h500); push(0, 32'h104); push(1, 32'h204);
    cmpl(1, 1'b0, 1'b0); wake(0); launch(5, 32'h500); cycle();
    cycle(); cycle(); cycle(); cycle();

    // R2/R7/R10 ignored strobes
    launch(1, 32'hDEAD); cmpl(3, 1'b0, 1'b0); wake(2); cycle();
    cycle(); cycle();
    chk(issue_valid_o == 1'b0, "R10 ignored strobes cause no issue", issue_valid_o, 0);
    push(1, 32'h208); cmpl(1, 1'b0, 1'b0); cycle();  // R2: PC unaffected by launch
    cycle(); cycle();

    // R8 exits
    cmpl(0, 1'b0, 1'b1); cycle();
    cmpl(1, 1'b0, 1'b1); cycle();
    cmpl(2, 1'b0, 1'b1); cycle();
    cycle();
    chk(done_o == 1'b0, "R9 done low with warp 5 live", done_o, 0);
    cmpl(5, 1'b1, 1'b1); cycle();
    cycle(); cycle();
    chk(done_o == 1'b1, "R8 R9 exit beats mem, all idle", done_o, 1);
    chk(issue_valid_o == 1'b0, "R9 no issue when done", issue_valid_o, 0);
    chk(exp_q.size() == 0, "R3 all expected issues seen", exp_q.size(), 0);
    finish_run();
  end
endmodule